// File: doc/BRIEF.md
# Rotating Edge-Clock Phase Offset Generator

This block sits between a multi-lane receiver's deskew logic and the phase interpolators that place each lane's sampling clocks. For every lane it takes a base interpolator code for the edge sampler and one for the data sampler. It adds a small, time-varying phase offset to the edge code only. The offsets sit at odd multiples of a programmable step: −3, −1, +1 and +3 steps for four lanes. They rotate so that every lane visits every level. Across the lanes, the binary edge detectors then act together as one detector that sees a widened, flattened jitter distribution. The combined detector responds roughly in proportion to the phase error, not only to its sign.

The rotation has 8 cycles, which matches the loop-filter update period. Each slot holds for two cycles. Lane k uses level entry (k + slot) mod 4 from the ordered list −3, −1, +1, +3. Because of this, the offsets sum to zero across the lanes in every cycle. They also sum to zero for each lane over a full period. Interpolator codes wrap around a ring of 60 steps: 10 coarse phases with 6 fine steps each, one fine step being 1/30 UI. Base codes must be below 60. The largest offset (3 × 7 steps) is smaller than the ring. With enable low, no offset is applied and the rotation is held at slot 0.

Top module: `phase_offset_rotator`

## Requirements
- R1: While reset is asserted, every edge and data output code is 0.
- R2: While enabled, the rotation slot advances by one (mod 4) every 2 cycles. The first two registered outputs after enable rises use slot 0. At slot t, lane k gets level 2·((k+t) mod 4) − 3, in steps.
- R3: In every enabled cycle, the edge offsets applied to the four lanes sum to zero.
- R4: Over any 8 consecutive enabled cycles aligned to the rotation, the offsets applied to one lane sum to zero.
- R5: Each data output code equals that lane's data base code from the previous cycle and never carries an offset.
- R6: Each edge output code equals (previous edge base + level × previous step) mod 60.
- R7: A sum below 0 wraps up by 60, and a sum of 60 or more wraps down by 60.
- R8: While enable is low, each edge output equals the previous edge base code. Raising enable restarts the rotation at slot 0.
- R9: A step of 0 leaves the edge codes equal to their base codes while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables offset rotation |
| step_i | input | 3 | Offset step size in fine interpolator steps |
| edge_base_i | input | 4×6 | Per-lane edge interpolator base (deskew) codes |
| data_base_i | input | 4×6 | Per-lane data interpolator base codes |
| edge_code_o | output | 4×6 | Per-lane edge interpolator codes with offset |
| data_code_o | output | 4×6 | Per-lane data interpolator codes |

## Verification
The hardest case to reach is a restart in the middle of a rotation. Enable must drop while a slot is half used and a lane's running sum is not zero. The pattern must then begin again at slot 0, not resume where it stopped. The bench drops enable after an odd number of cycles, checks that the edge codes equal their bases while idle, and then follows a full period from slot 0. Wrapping is reached with bases near both ends of the ring and the largest step, so that the −3 and +3 levels cross the ring boundary.

// File: rtl/phofs_pkg.sv
package phofs_pkg;

    // Offset level (in steps) for a lane at a given rotation slot:
    // odd multiples symmetric about zero, e.g. -3,-1,+1,+3 for four lanes.
    function automatic int lane_level(input int lane, input int slot, input int lanes);
        return 2 * ((lane + slot) % lanes) - (lanes - 1);
    endfunction

    // Single-correction wrap onto a ring of 'range_n' codes; the caller
    // guarantees the input lies within one ring length of the valid range.
    function automatic int wrap_code(input int sum, input int range_n);
        if (sum < 0)
            return sum + range_n;
        else if (sum >= range_n)
            return sum - range_n;
        return sum;
    endfunction

endpackage

// File: rtl/phofs_rotor.sv
module phofs_rotor #(
    parameter int NUM_LANES   = 4,
    parameter int HOLD_CYCLES = 2,
    localparam int SLOT_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
    localparam int HOLD_W     = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [SLOT_W-1:0] slot_o
);

    typedef struct packed {
        logic [HOLD_W-1:0] hold;
        logic [SLOT_W-1:0] slot;
    } rot_state_t;

    rot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (st_q.hold == HOLD_W'(HOLD_CYCLES - 1)) begin
            st_d.hold = '0;
            st_d.slot = (st_q.slot == SLOT_W'(NUM_LANES - 1)) ? '0 : st_q.slot + 1'b1;
        end else begin
            st_d.hold = st_q.hold + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign slot_o = st_q.slot;

    // R2: slot moves on by exactly one after its last held cycle
    p_slot_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.hold == HOLD_W'(HOLD_CYCLES - 1))
        |=> (int'(st_q.slot) == (int'($past(st_q.slot)) + 1) % NUM_LANES));

    // R2: slot stays put while it is still being held
    p_slot_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.hold != HOLD_W'(HOLD_CYCLES - 1)) |=> $stable(st_q.slot));

    // R8: idle returns the rotation to its start
    p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.slot == '0 && st_q.hold == '0));

endmodule

// File: rtl/phofs_lane.sv
module phofs_lane
    import phofs_pkg::*;
#(
    parameter int NUM_LANES  = 4,
    parameter int LANE_IDX   = 0,
    parameter int CODE_RANGE = 60,
    parameter int STEP_W     = 3,
    localparam int CODE_W    = $clog2(CODE_RANGE),
    localparam int SLOT_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [CODE_W-1:0] edge_base_i,
    input  logic [CODE_W-1:0] data_base_i,
    output logic [CODE_W-1:0] edge_code_o,
    output logic [CODE_W-1:0] data_code_o
);

    typedef struct packed {
        logic [CODE_W-1:0] edge_code;
        logic [CODE_W-1:0] data_code;
    } lane_state_t;

    lane_state_t st_d, st_q;
    int          level;
    int          offset;
    int          wrapped;

    always_comb begin
        level   = lane_level(LANE_IDX, int'(slot_i), NUM_LANES);
        offset  = en ? level * int'(step_i) : 0;
        wrapped = wrap_code(int'(edge_base_i) + offset, CODE_RANGE);
        st_d.edge_code = CODE_W'(wrapped);
        st_d.data_code = data_base_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign edge_code_o = st_q.edge_code;
    assign data_code_o = st_q.data_code;

    // R5: data path is a plain one-cycle copy
    p_data_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (data_code_o == $past(data_base_i)));

    // R8: no offset while disabled
    p_idle_no_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (edge_code_o == $past(edge_base_i)));

    // R7: edge code stays on the ring when base codes are valid
    p_code_on_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(edge_base_i) < CODE_RANGE) |=> (int'(edge_code_o) < CODE_RANGE));

endmodule

// File: rtl/phase_offset_rotator.sv
module phase_offset_rotator #(
    parameter int NUM_LANES       = 4,
    parameter int HOLD_CYCLES     = 2,
    parameter int COARSE_PHASES   = 10,
    parameter int STEPS_PER_PHASE = 6,
    parameter int STEP_W          = 3,
    localparam int CODE_RANGE     = COARSE_PHASES * STEPS_PER_PHASE,
    localparam int CODE_W         = $clog2(CODE_RANGE),
    localparam int SLOT_W         = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic [STEP_W-1:0]                 step_i,
    input  logic [NUM_LANES-1:0][CODE_W-1:0]  edge_base_i,
    input  logic [NUM_LANES-1:0][CODE_W-1:0]  data_base_i,
    output logic [NUM_LANES-1:0][CODE_W-1:0]  edge_code_o,
    output logic [NUM_LANES-1:0][CODE_W-1:0]  data_code_o
);

    logic [SLOT_W-1:0] slot;

    phofs_rotor #(
        .NUM_LANES  (NUM_LANES),
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_rotor (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .slot_o(slot)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        phofs_lane #(
            .NUM_LANES (NUM_LANES),
            .LANE_IDX  (k),
            .CODE_RANGE(CODE_RANGE),
            .STEP_W    (STEP_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en),
            .slot_i     (slot),
            .step_i     (step_i),
            .edge_base_i(edge_base_i[k]),
            .data_base_i(data_base_i[k]),
            .edge_code_o(edge_code_o[k]),
            .data_code_o(data_code_o[k])
        );
    end

    // R9: a zero step leaves edge codes on their bases
    p_zero_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == '0) |=> (edge_code_o == $past(edge_base_i)));

endmodule

// File: tb/phase_offset_rotator_bench.sv
module phase_offset_rotator_bench;

    localparam int L     = 4;
    localparam int CW    = 6;
    localparam int RANGE = 60;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                en = 1'b0;
    logic [2:0]          step = '0;
    logic [L-1:0][CW-1:0] ebase = '0;
    logic [L-1:0][CW-1:0] dbase = '0;
    logic [L-1:0][CW-1:0] ecode;
    logic [L-1:0][CW-1:0] dcode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    phase_offset_rotator u_phase_offset_rotator (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .step_i     (step),
        .edge_base_i(ebase),
        .data_base_i(dbase),
        .edge_code_o(ecode),
        .data_code_o(dcode)
    );

    // Level table from R2: ordered list -3,-1,+1,+3 indexed by (k+t) mod 4
    function automatic int lvl(input int k, input int t);
        return 2 * ((k + t) % 4) - 3;
    endfunction

    function automatic int ring(input int v);
        return ((v % RANGE) + RANGE) % RANGE;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run n enabled cycles from a fresh enable; check each lane per R2/R6/R7
    task automatic run_enabled(input string req, input int n);
        en = 1'b1;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            for (int k = 0; k < L; k++)
                check(req, int'(ecode[k]),
                      ring(int'(ebase[k]) + lvl(k, (c / 2) % 4) * int'(step)));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int k = 0; k < L; k++) begin
            check("R1 edge", int'(ecode[k]), 0);
            check("R1 data", int'(dcode[k]), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic_pattern();
        step = 3'd2;
        for (int k = 0; k < L; k++) begin
            ebase[k] = CW'(20 + 3 * k);
            dbase[k] = CW'(40 + k);
        end
        run_enabled("R2/R6 pattern", 16);
    endtask

    task automatic t_zero_sums();
        int lane_sum [L];
        step = 3'd1;
        for (int k = 0; k < L; k++) begin
            ebase[k] = CW'(30);
            lane_sum[k] = 0;
        end
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        for (int c = 0; c < 8; c++) begin
            int sum_now;
            @(negedge clk);
            sum_now = 0;
            for (int k = 0; k < L; k++) begin
                sum_now += int'(ecode[k]) - 30;
                lane_sum[k] += int'(ecode[k]) - 30;
            end
            check("R3 lane sum zero", sum_now, 0);
        end
        for (int k = 0; k < L; k++)
            check("R4 period sum zero", lane_sum[k], 0);
    endtask

    task automatic t_wrap();
        en = 1'b0;
        step = 3'd7;
        ebase[0] = CW'(1);
        ebase[1] = CW'(58);
        ebase[2] = CW'(0);
        ebase[3] = CW'(59);
        @(negedge clk);
        run_enabled("R7 wrap", 8);
    endtask

    task automatic t_data_pass();
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < L; k++)
                dbase[k] = CW'((p * 17 + k * 11) % RANGE);
            @(negedge clk);
            for (int k = 0; k < L; k++)
                check("R5 data pass", int'(dcode[k]), (p * 17 + k * 11) % RANGE);
        end
    endtask

    task automatic t_idle_restart();
        step = 3'd3;
        for (int k = 0; k < L; k++) ebase[k] = CW'(25 + k);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < L; k++)
            check("R8 idle no offset", int'(ecode[k]), 25 + k);
        @(negedge clk);
        run_enabled("R8 restart slot 0", 8);
    endtask

    task automatic t_zero_step();
        step = 3'd0;
        for (int k = 0; k < L; k++) ebase[k] = CW'(7 * k + 5);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            for (int k = 0; k < L; k++)
                check("R9 zero step", int'(ecode[k]), 7 * k + 5);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic_pattern();
                t_zero_sums();
                t_wrap();
                t_data_pass();
                t_idle_restart();
                t_zero_step();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule